// File: doc/BRIEF.md
# Mains-Gated Reference Period Counter

This block gives a relative reading of the mains frequency. A pulse derived from the mains (nominally 60 Hz) is divided by a fixed ratio to form a gate of about one second. During each gate the block counts rising edges of a slow local reference (nominally 6 kHz). A nominal mains supply therefore reads about 6000. A higher mains frequency shortens the gate and lowers the reading. No absolute timebase is assumed: the result is only as good as the reference.

Both the mains pulse and the reference are asynchronous to the system clock. Each one passes through a two-flop synchroniser, and a rising-edge detector turns it into a single-cycle event. A modulo-N prescaler turns every N-th mains edge into a gate event. On a gate event the finished count goes to a held output register and a one-cycle valid strobe is raised. Counting then restarts from zero in that same cycle, so no reference edge is lost between measurements. The accumulator saturates at its all-ones value and sets an overflow flag, which is published together with the count it belongs to.

Top module: `mains_freq_meter`

## Requirements
- R1: While reset (synchronous, active high) is applied, and in the first cycle after it, `count_o` is 0, `valid_o` is 0 and `ovf_o` is 0. Reset also clears the synchronisers, the prescaler, the accumulator and the armed state.
- R2: The first gate event after reset only starts a measurement. It raises no `valid_o` and leaves `count_o` and `ovf_o` unchanged.
- R3: From the second gate event onward, `valid_o` is high for exactly one cycle per gate event. A gate event happens on every `GATE_DIV`-th mains rising edge, and at no other time.
- R4: On a valid strobe, `count_o` equals the number of reference rising edges seen since the previous gate event.
- R5: A reference edge that arrives in the same cycle as a gate event is counted in the measurement being closed. The next measurement starts at zero.
- R6: The accumulator saturates at 2^`CNT_W`-1. A reference edge that arrives at that value sets the overflow indication. `ovf_o` is published with the count it belongs to, so `ovf_o` high implies `count_o` is all ones. Overflow is cleared for the next measurement.
- R7: Between valid strobes, `count_o` and `ovf_o` hold their values.
- R8: Only rising edges are counted. An input held high for several cycles counts once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mains_i | input | 1 | Mains-derived pulse, asynchronous |
| ref_i | input | 1 | Local reference clock, asynchronous |
| count_o | output | CNT_W | Last completed measurement |
| valid_o | output | 1 | One-cycle strobe when `count_o` is updated |
| ovf_o | output | 1 | Saturation flag belonging to `count_o` |

## Verification
The bench builds the block with `CNT_W` = 5 and `GATE_DIV` = 5 rather than the defaults of 13 and 60. With these values a gate closes every few mains edges, and a burst of about thirty reference edges drives the accumulator into saturation. This makes overflow, the clearing of overflow in the following measurement, and many back-to-back gates reachable in a few thousand cycles. The random phases alternate between sparse and dense reference activity and insert long-held input levels. Directed cases cover the first gate after reset, a reference edge that coincides with a gate, and a reset in the middle of a measurement.

// File: rtl/freq_meter_pkg.sv
package freq_meter_pkg;

    // Default sizing: about 6000 counts per one-second gate at nominal mains.
    localparam int unsigned DEF_CNT_W       = 13;
    localparam int unsigned DEF_GATE_DIV    = 60;
    localparam int unsigned DEF_SYNC_STAGES = 2;

    // Whether a measurement window is already open.
    typedef enum logic {
        PH_IDLE  = 1'b0,
        PH_ARMED = 1'b1
    } meas_phase_e;

endpackage

// File: rtl/edge_sync.sv
module edge_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_i,
    output logic rise_o
);
    localparam int unsigned NST = (STAGES < 2) ? 2 : STAGES;

    typedef struct packed {
        logic [NST-1:0] chain;
        logic           last;
    } sync_st_t;

    sync_st_t s_d, s_q;

    always_comb begin
        s_d       = s_q;
        s_d.chain = {s_q.chain[NST-2:0], async_i};
        s_d.last  = s_q.chain[NST-1];
        if (rst) begin
            s_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        s_q <= s_d;
    end

    assign rise_o = s_q.chain[NST-1] & ~s_q.last;

endmodule

// File: rtl/gate_prescaler.sv
module gate_prescaler #(
    parameter int unsigned DIV = 60
) (
    input  logic clk,
    input  logic rst,
    input  logic edge_i,
    output logic gate_o
);
    localparam int unsigned PW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(DIV - 1);

    typedef struct packed {
        logic [PW-1:0] cnt;
    } pre_st_t;

    pre_st_t p_d, p_q;
    logic    wrap;

    assign wrap = (p_q.cnt == LAST);

    always_comb begin
        p_d = p_q;
        if (edge_i) begin
            p_d.cnt = wrap ? '0 : p_q.cnt + 1'b1;
        end
        if (rst) begin
            p_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        p_q <= p_d;
    end

    assign gate_o = edge_i & wrap;

endmodule

// File: rtl/period_counter.sv
module period_counter
    import freq_meter_pkg::*;
#(
    parameter int unsigned CNT_W = 13
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_i,
    input  logic             gate_i,
    output logic [CNT_W-1:0] count_o,
    output logic             valid_o,
    output logic             ovf_o
);
    localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

    typedef struct packed {
        logic [CNT_W-1:0] acc;
        logic             acc_ovf;
        logic [CNT_W-1:0] hold;
        logic             hold_ovf;
        logic             valid;
        meas_phase_e      phase;
    } cnt_st_t;

    cnt_st_t          c_d, c_q;
    logic [CNT_W-1:0] sum;
    logic             sum_ovf;

    // Accumulator value including this cycle's tick, saturating.
    always_comb begin
        sum     = c_q.acc;
        sum_ovf = c_q.acc_ovf;
        if (tick_i) begin
            if (c_q.acc == CMAX) begin
                sum_ovf = 1'b1;
            end else begin
                sum = c_q.acc + 1'b1;
            end
        end
    end

    always_comb begin
        c_d       = c_q;
        c_d.valid = 1'b0;
        if (gate_i) begin
            if (c_q.phase == PH_ARMED) begin
                c_d.hold     = sum;
                c_d.hold_ovf = sum_ovf;
                c_d.valid    = 1'b1;
            end
            c_d.phase   = PH_ARMED;
            c_d.acc     = '0;
            c_d.acc_ovf = 1'b0;
        end else begin
            c_d.acc     = sum;
            c_d.acc_ovf = sum_ovf;
        end
        if (rst) begin
            c_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        c_q <= c_d;
    end

    assign count_o = c_q.hold;
    assign valid_o = c_q.valid;
    assign ovf_o   = c_q.hold_ovf;

endmodule

// File: rtl/mains_freq_meter.sv
module mains_freq_meter
    import freq_meter_pkg::*;
#(
    parameter int unsigned CNT_W       = DEF_CNT_W,
    parameter int unsigned GATE_DIV    = DEF_GATE_DIV,
    parameter int unsigned SYNC_STAGES = DEF_SYNC_STAGES
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             mains_i,
    input  logic             ref_i,
    output logic [CNT_W-1:0] count_o,
    output logic             valid_o,
    output logic             ovf_o
);
    logic mains_rise_w;
    logic ref_tick_w;
    logic gate_w;

    edge_sync #(.STAGES(SYNC_STAGES)) u_mains_sync (
        .clk     (clk),
        .rst     (rst),
        .async_i (mains_i),
        .rise_o  (mains_rise_w)
    );

    edge_sync #(.STAGES(SYNC_STAGES)) u_ref_sync (
        .clk     (clk),
        .rst     (rst),
        .async_i (ref_i),
        .rise_o  (ref_tick_w)
    );

    gate_prescaler #(.DIV(GATE_DIV)) u_prescale (
        .clk    (clk),
        .rst    (rst),
        .edge_i (mains_rise_w),
        .gate_o (gate_w)
    );

    period_counter #(.CNT_W(CNT_W)) u_count (
        .clk     (clk),
        .rst     (rst),
        .tick_i  (ref_tick_w),
        .gate_i  (gate_w),
        .count_o (count_o),
        .valid_o (valid_o),
        .ovf_o   (ovf_o)
    );

endmodule

// File: rtl/mains_freq_meter_chk.sv
module mains_freq_meter_chk #(
    parameter int unsigned CNT_W = 13
) (
    input logic             clk,
    input logic             rst,
    input logic [CNT_W-1:0] count_o,
    input logic             valid_o,
    input logic             ovf_o,
    input logic             gate_w
);
    localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

    logic rst_seen = 1'b0;

    always_ff @(posedge clk) begin
        rst_seen <= rst;
        // R1
        if (rst_seen) begin
            reset_clear_chk: assert (count_o == '0 && !valid_o && !ovf_o);
        end
    end

    // R3
    valid_single_chk: assert property (@(posedge clk) disable iff (rst)
        valid_o |=> !valid_o);

    // R3
    valid_from_gate_chk: assert property (@(posedge clk) disable iff (rst)
        valid_o |-> $past(gate_w));

    // R7
    hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
        !valid_o |-> ($stable(count_o) && $stable(ovf_o)));

    // R6
    ovf_saturated_chk: assert property (@(posedge clk) disable iff (rst)
        ovf_o |-> (count_o == CMAX));

endmodule

bind mains_freq_meter mains_freq_meter_chk #(.CNT_W(CNT_W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .count_o (count_o),
    .valid_o (valid_o),
    .ovf_o   (ovf_o),
    .gate_w  (gate_w)
);

// File: tb/mains_freq_meter_tb.sv
`timescale 1ns/1ps
module mains_freq_meter_tb;
    localparam int unsigned W   = 5;
    localparam int unsigned DIV = 5;
    localparam logic [W-1:0] CMAX = {W{1'b1}};

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         mains_i = 1'b0;
    logic         ref_i = 1'b0;
    logic [W-1:0] count_o;
    logic         valid_o;
    logic         ovf_o;

    int n_chk = 0;
    int n_bad = 0;
    int vseen = 0;
    int cycles = 0;

    // model state
    int      m_cnt = 0;
    int      acc = 0;
    bit      acc_ovf = 0;
    bit      armed = 0;
    int      exp_cnt = 0;
    bit      exp_ovf = 0;

    always #5 clk = ~clk;

    mains_freq_meter #(.CNT_W(W), .GATE_DIV(DIV)) u_dut (
        .clk(clk), .rst(rst), .mains_i(mains_i), .ref_i(ref_i),
        .count_o(count_o), .valid_o(valid_o), .ovf_o(ovf_o)
    );

    always @(negedge clk) if (valid_o) vseen++;

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_bad++;
            $display("FAIL watchdog: actual=%0d cycles expected<=150000", cycles);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    task automatic check(input string tag, input int act, input int expv);
        n_chk++;
        if (act != expv) begin
            n_bad++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    function automatic int next_acc(input int a);
        return (a == int'(CMAX)) ? a : a + 1;
    endfunction

    // One event slot: inputs high for hi negedges, low for 4; checks after.
    task automatic slot(input bit m, input bit r, input int hi);
        bit gate = 0;
        bit expv = 0;
        bit coinc;
        vseen = 0;
        mains_i = m;
        ref_i   = r;
        repeat (hi) @(negedge clk);
        mains_i = 0;
        ref_i   = 0;
        repeat (4) @(negedge clk);
        if (r) begin
            if (acc == int'(CMAX)) acc_ovf = 1;
            acc = next_acc(acc);
        end
        coinc = m && r;
        if (m) begin
            m_cnt++;
            if (m_cnt == DIV) begin
                m_cnt = 0;
                gate  = 1;
                if (armed) begin
                    exp_cnt = acc;
                    exp_ovf = acc_ovf;
                    expv    = 1;
                end
                armed   = 1;
                acc     = 0;
                acc_ovf = 0;
            end
        end
        if (gate && !expv) check("R2 first gate no strobe", vseen, 0);
        else               check("R3 strobe count", vseen, int'(expv));
        if (expv && coinc)     check("R5 coincident tick", int'(count_o), exp_cnt);
        else if (expv)         check("R4 latched count", int'(count_o), exp_cnt);
        else                   check("R7 held count", int'(count_o), exp_cnt);
        check("R6 overflow flag", int'(ovf_o), int'(exp_ovf));
    endtask

    task automatic do_reset();
        rst = 1;
        mains_i = 0;
        ref_i = 0;
        repeat (3) @(negedge clk);
        check("R1 count after reset", int'(count_o), 0);
        check("R1 valid after reset", int'(valid_o), 0);
        check("R1 ovf after reset", int'(ovf_o), 0);
        rst = 0;
        @(negedge clk);
        check("R1 count first cycle", int'(count_o), 0);
        m_cnt = 0; acc = 0; acc_ovf = 0; armed = 0; exp_cnt = 0; exp_ovf = 0;
    endtask

    initial begin
        void'($urandom(32'd20240611));
        do_reset();

        // R2: first gate with refs pending
        for (int i = 0; i < DIV - 1; i++) slot(1, 1, 2);
        slot(1, 0, 2);
        // R4: plain measurement
        for (int i = 0; i < 7; i++) slot(0, 1, 2);
        for (int i = 0; i < DIV - 1; i++) slot(1, 0, 2);
        slot(1, 0, 2);
        // R5: gate coincident with tick
        for (int i = 0; i < 3; i++) slot(0, 1, 2);
        for (int i = 0; i < DIV - 1; i++) slot(1, 0, 2);
        slot(1, 1, 2);
        // R8: long-held levels count once
        slot(0, 1, 12);
        slot(0, 1, 9);
        for (int i = 0; i < DIV - 1; i++) slot(1, 0, 10);
        slot(1, 0, 2);
        // R6: saturation, then cleared in next measurement
        for (int i = 0; i < 40; i++) slot(0, 1, 2);
        for (int i = 0; i < DIV; i++) slot(1, 1, 2);
        check("R6 ovf set after burst", int'(ovf_o), 1);
        check("R6 count saturated", int'(count_o), int'(CMAX));
        for (int i = 0; i < DIV; i++) slot(1, 0, 2);
        check("R6 ovf cleared next", int'(ovf_o), 0);

        // constrained random, alternating sparse and dense reference
        for (int ph = 0; ph < 6; ph++) begin
            for (int i = 0; i < 120; i++) begin
                bit m = ($urandom_range(3) == 0);
                bit r = (ph % 2 == 0) ? ($urandom_range(1) == 0)
                                      : ($urandom_range(19) != 0);
                int hi = ($urandom_range(7) == 0) ? int'($urandom_range(8, 3)) : 2;
                slot(m, r, hi);
            end
        end

        // R1: reset mid-measurement, then R2 again
        for (int i = 0; i < 3; i++) slot(1, 1, 2);
        do_reset();
        for (int i = 0; i < DIV; i++) slot(1, 1, 2);
        for (int i = 0; i < DIV; i++) slot(1, 1, 2);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule